// File: doc/BRIEF.md
# Serial Receive Path with Break and Framing Detection

This block turns an asynchronous serial input into characters and queues them in a receive FIFO. The receiver counts a 16x oversampling tick, which comes from an external baud generator. It accepts 5 to 8 data bits, optional even or odd parity, and one or two stop bits. Each character goes into the FIFO together with three tags: break, framing and parity.

The status outputs always describe the character at the head of the FIFO. A status read clears the flags of that head entry. A data read pops the head, and the next entry then shows its own flags. Data-ready is the only request signal. It is high while the FIFO holds anything.

The line may stay low through a whole frame, from the start bit up to the stop-bit sample point. The receiver then stores exactly one zero character marked as a break, and it waits for the line to go high again before it looks for a new start bit. When a stop bit is sampled low on a character that has at least one high bit, the character is tagged with a framing error. That low stop position is then taken as the start bit of the next character.

Top module: `uart_rx_line`

## Requirements
- R1: After reset, data_ready is 0 and st_break, st_frame and st_parity are all 0.
- R2: A character is a low start bit followed by 5 + cfg_data_bits data bits, least significant bit first (cfg_data_bits 0..3 selects 5..8 bits). The data bits not received read as 0 on data_out. data_ready is 1 exactly while the FIFO is not empty.
- R3: When cfg_par_en is 1, a parity bit follows the data. With cfg_par_odd = 0 the count of ones in the data and parity bit together must be even; with cfg_par_odd = 1 it must be odd. A mismatch tags the character with the parity flag. When cfg_par_en is 0, no parity bit is expected and the parity flag stays 0.
- R4: A low pulse that is gone by the middle of the start bit queues nothing.
- R5: A character whose first stop bit is sampled low, and which had at least one high data or parity bit, is queued with the frame flag set.
- R6: With cfg_two_stop = 1, the level of the second stop bit is not checked. A low second stop bit neither tags the character nor starts a new one.
- R7: After a framing error, the low stop position counts as the start bit. The following bit periods are received as the data of a new character.
- R8: If the line stays low from the start bit through the stop-bit sample point, exactly one entry is queued, whatever the length of the low period. That entry has data 0x00, the break flag set, and the frame and parity flags clear. Reception resumes once the line is high again.
- R9: st_break, st_frame and st_parity show the tags of the FIFO head entry, not the newest entry, and are 0 while the FIFO is empty.
- R10: A one-cycle rd_status pulse clears all three flags of the current head entry in the following cycle. data_out and data_ready are unchanged. After a pop, the new head shows its own tags.
- R11: Characters leave the FIFO in arrival order. A character that arrives while all DEPTH entries are occupied is lost.
- R12: rd_data while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_data_bits | input | 2 | Data bits minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Two stop bits per frame |
| rd_data | input | 1 | Pop the head character |
| rd_status | input | 1 | Status read; clears the head flags |
| data_out | output | 8 | Head character data |
| data_ready | output | 1 | FIFO not empty |
| st_break | output | 1 | Head entry is a break |
| st_frame | output | 1 | Head entry had a low stop bit |
| st_parity | output | 1 | Head entry failed parity |

## Verification
Random frames vary the data width, parity mode, stop count, data values and parity correctness. Together they separate bit ordering, masking of the unused bits and the sense of the parity check. Directed patterns cover the rest:
- A short start glitch separates real start bits from noise.
- A low stop bit followed by bare data bits separates resynchronisation from a return to idle.
- A long low line separates a single break entry from repeated zero characters.
- A clean character queued ahead of a faulty one shows whether the flags follow the head or the newest arrival.
- An overfilled FIFO and pops on an empty FIFO probe the pointer handling.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int unsigned CHAR_W = 8;

   typedef struct packed {
      logic              brk;
      logic              frm;
      logic              par;
      logic [CHAR_W-1:0] data;
   } rx_char_t;

   typedef enum logic [2:0] {
      S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2, S_BRK
   } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '1;
            end else begin
               q[0] <= d_in;
               for (int i = 1; i < int'(STAGES); i++) q[i] <= q[i-1];
            end
         end
         assign d_out = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
   import uart_rx_pkg::*;
#(
   parameter int unsigned STOP2_TICKS = 26
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx,
   input  logic [1:0] cfg_data_bits,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic       cfg_two_stop,
   output logic       push,
   output rx_char_t   push_char
);
   localparam int unsigned CW = $clog2(STOP2_TICKS + 1) > 4 ? $clog2(STOP2_TICKS + 1) : 4;
   localparam logic [CW-1:0] MID_CNT  = CW'(7);
   localparam logic [CW-1:0] BIT_CNT  = CW'(15);
   localparam logic [CW-1:0] STOP2_CNT = CW'(STOP2_TICKS - 1);

   rx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [2:0]        bidx;
   logic [CHAR_W-1:0] shreg;
   logic              par_acc, saw_one, par_bad;
   logic [2:0]        last_idx;

   assign last_idx = 3'd4 + {1'b0, cfg_data_bits};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         cnt       <= '0;
         bidx      <= '0;
         shreg     <= '0;
         par_acc   <= 1'b0;
         saw_one   <= 1'b0;
         par_bad   <= 1'b0;
         push      <= 1'b0;
         push_char <= '0;
      end else begin
         push <= 1'b0;
         if (tick) begin
            unique case (state)
               S_IDLE: begin
                  if (!rx) begin
                     state <= S_START;
                     cnt   <= '0;
                  end
               end
               S_START: begin
                  if (cnt == MID_CNT) begin
                     cnt <= '0;
                     if (!rx) begin
                        state   <= S_DATA;
                        bidx    <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        saw_one <= 1'b0;
                        par_bad <= 1'b0;
                     end else begin
                        state <= S_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_DATA: begin
                  if (cnt == BIT_CNT) begin
                     cnt         <= '0;
                     shreg[bidx] <= rx;
                     par_acc     <= par_acc ^ rx;
                     saw_one     <= saw_one | rx;
                     if (bidx == last_idx) state <= cfg_par_en ? S_PAR : S_STOP;
                     else                  bidx  <= bidx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_PAR: begin
                  if (cnt == BIT_CNT) begin
                     cnt     <= '0;
                     par_bad <= rx ^ par_acc ^ cfg_par_odd;
                     saw_one <= saw_one | rx;
                     state   <= S_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_STOP: begin
                  if (cnt == BIT_CNT) begin
                     cnt  <= '0;
                     push <= 1'b1;
                     if (rx) begin
                        push_char <= '{brk: 1'b0, frm: 1'b0, par: par_bad, data: shreg};
                        state     <= cfg_two_stop ? S_STOP2 : S_IDLE;
                     end else if (!saw_one) begin
                        push_char <= '{brk: 1'b1, frm: 1'b0, par: 1'b0, data: '0};
                        state     <= S_BRK;
                     end else begin
                        // low stop slot becomes the start bit of the next character
                        push_char <= '{brk: 1'b0, frm: 1'b1, par: par_bad, data: shreg};
                        state     <= S_DATA;
                        bidx      <= '0;
                        shreg     <= '0;
                        par_acc   <= 1'b0;
                        saw_one   <= 1'b0;
                        par_bad   <= 1'b0;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_STOP2: begin
                  if (cnt == STOP2_CNT) begin
                     cnt   <= '0;
                     state <= S_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_BRK: begin
                  if (rx) state <= S_IDLE;
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
   import uart_rx_pkg::*;
#(
   parameter int unsigned DEPTH = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  rx_char_t wdata,
   input  logic     pop,
   output rx_char_t rdata,
   output logic     empty,
   output logic     pop_fire
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   rx_char_t      mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [AW:0]   count;
   logic          push_ok;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty    = (count == '0);
   assign push_ok  = push && (count != FULL_CNT);
   assign pop_fire = pop && !empty;
   assign rdata    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok)  wr_ptr <= wr_nxt;
         if (pop_fire) rd_ptr <= rd_nxt;
         unique case ({push_ok, pop_fire})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_line.sv
module uart_rx_line
   import uart_rx_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       rxd,
   input  logic [1:0] cfg_data_bits,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic       cfg_two_stop,
   input  logic       rd_data,
   input  logic       rd_status,
   output logic [7:0] data_out,
   output logic       data_ready,
   output logic       st_break,
   output logic       st_frame,
   output logic       st_parity
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_rx_line: DEPTH must be at least 2");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("uart_rx_line: SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic     rx_s, push, empty, pop_fire, cleared;
   rx_char_t push_char, head;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(rxd), .d_out(rx_s)
   );

   uart_rx_deser u_deser (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
      .cfg_data_bits(cfg_data_bits), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
      .push(push), .push_char(push_char)
   );

   uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_char),
      .pop(rd_data), .rdata(head), .empty(empty), .pop_fire(pop_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cleared <= 1'b0;
      else if (pop_fire)            cleared <= 1'b0;
      else if (rd_status && !empty) cleared <= 1'b1;
   end

   assign data_ready = !empty;
   assign data_out   = empty ? '0 : head.data;
   assign st_break   = !empty && !cleared && head.brk;
   assign st_frame   = !empty && !cleared && head.frm;
   assign st_parity  = !empty && !cleared && head.par;
endmodule

// File: rtl/uart_rx_line_chk.sv
module uart_rx_line_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_data,
   input logic       rd_status,
   input logic [7:0] data_out,
   input logic       data_ready,
   input logic       st_break,
   input logic       st_frame,
   input logic       st_parity
);
   p_flags_need_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !data_ready |-> !(st_break || st_frame || st_parity));

   p_break_entry_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      st_break |-> (data_out == 8'h00) && !st_frame && !st_parity);

   p_status_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_status && data_ready && !rd_data |=> !(st_break || st_frame || st_parity));

   p_head_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready && !rd_data |=> data_ready && $stable(data_out));

   p_break_no_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready && !st_break && !rd_data |=> !st_break);
endmodule

bind uart_rx_line uart_rx_line_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_status(rd_status),
   .data_out(data_out), .data_ready(data_ready), .st_break(st_break),
   .st_frame(st_frame), .st_parity(st_parity)
);

// File: tb/tb_uart_rx_line.sv
module tb_uart_rx_line;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n, rxd, par_en, par_odd, two_stop, rd_data, rd_status;
   logic [1:0] dbits;
   logic [1:0] tdiv = 2'd0;
   logic       tick16;
   logic [7:0] data_out;
   logic       data_ready, st_break, st_frame, st_parity;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;
   logic [10:0] expq[$];

   always #2 clk = ~clk;
   always @(posedge clk) tdiv <= tdiv + 2'd1;
   assign tick16 = (tdiv == 2'd3);

   uart_rx_line #(.DEPTH(DEPTH), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
      .cfg_data_bits(dbits), .cfg_par_en(par_en), .cfg_par_odd(par_odd),
      .cfg_two_stop(two_stop), .rd_data(rd_data), .rd_status(rd_status),
      .data_out(data_out), .data_ready(data_ready), .st_break(st_break),
      .st_frame(st_frame), .st_parity(st_parity)
   );

   function automatic logic [7:0] mask_of(input logic [1:0] c);
      return 8'hFF >> (3 - c);
   endfunction

   function automatic logic par_of(input logic [7:0] d, input logic odd);
      return (^d) ^ odd;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] db, input logic pe, input logic po, input logic ts);
      dbits = db; par_en = pe; par_odd = po; two_stop = ts;
   endtask

   task automatic bit_out(input logic v);
      rxd = v;
      repeat (64) @(negedge clk);
   endtask

   task automatic frame(input logic [7:0] d, input logic badp, input logic s1, input logic s2);
      bit_out(1'b0);
      for (int i = 0; i < 5 + int'(dbits); i++) bit_out(d[i]);
      if (par_en) bit_out(par_of(d & mask_of(dbits), par_odd) ^ badp);
      bit_out(s1);
      if (two_stop) bit_out(s2);
      rxd = 1'b1;
      repeat (40) @(negedge clk);
   endtask

   task automatic expect_push(input logic [10:0] e);
      if (expq.size() < DEPTH) expq.push_back(e);
   endtask

   task automatic send_good(input logic [7:0] d, input logic badp);
      frame(d, badp, 1'b1, 1'b1);
      expect_push({2'b00, par_en & badp, d & mask_of(dbits)});
   endtask

   task automatic drain_one(input string req);
      logic [10:0] e;
      logic [7:0]  held;
      e = expq.pop_front();
      check(data_ready === 1'b1, req, "data_ready", 32'(data_ready), 32'd1);
      check(data_out === e[7:0], req, "data_out", 32'(data_out), 32'(e[7:0]));
      check({st_break, st_frame, st_parity} === e[10:8], {req, " R9"}, "head flags",
            32'({st_break, st_frame, st_parity}), 32'(e[10:8]));
      held = data_out;
      rd_status = 1'b1;
      @(negedge clk);
      rd_status = 1'b0;
      check({st_break, st_frame, st_parity} === 3'b000, "R10", "flags after status read",
            32'({st_break, st_frame, st_parity}), 32'd0);
      check(data_out === held && data_ready === 1'b1, "R10", "data after status read",
            32'(data_out), 32'(held));
      rd_data = 1'b1;
      @(negedge clk);
      rd_data = 1'b0;
   endtask

   task automatic drain_all(input string req);
      while (expq.size() > 0) drain_one(req);
      check(data_ready === 1'b0, req, "empty after drain", 32'(data_ready), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2024);
      rst_n = 1'b0; rxd = 1'b1; rd_data = 1'b0; rd_status = 1'b0;
      cfg(2'd3, 1'b0, 1'b0, 1'b0);
      repeat (5) @(negedge clk);
      check(data_ready === 1'b0, "R1", "data_ready in reset", 32'(data_ready), 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check({data_ready, st_break, st_frame, st_parity} === 4'b0, "R1", "outputs after reset",
            32'({data_ready, st_break, st_frame, st_parity}), 32'd0);

      // R2: 8 data bits, then 5 data bits with upper bits masked
      send_good(8'hA5, 1'b0);
      drain_all("R2");
      cfg(2'd0, 1'b0, 1'b0, 1'b0);
      send_good(8'hFF, 1'b0);
      send_good(8'h0A, 1'b0);
      drain_all("R2");

      // R3: parity good and bad, both senses
      cfg(2'd3, 1'b1, 1'b0, 1'b0);
      send_good(8'h37, 1'b0);
      send_good(8'h37, 1'b1);
      cfg(2'd2, 1'b1, 1'b1, 1'b0);
      send_good(8'h55, 1'b0);
      send_good(8'h55, 1'b1);
      drain_all("R3");

      // R4: glitch shorter than half a bit
      cfg(2'd3, 1'b0, 1'b0, 1'b0);
      rxd = 1'b0;
      repeat (16) @(negedge clk);
      rxd = 1'b1;
      repeat (300) @(negedge clk);
      check(data_ready === 1'b0, "R4", "glitch queued nothing", 32'(data_ready), 32'd0);

      // R5 + R7: low stop bit, then bare data bits resynchronised
      bit_out(1'b0);
      for (int i = 0; i < 8; i++) bit_out(logic'((8'h3C >> i) & 1));
      bit_out(1'b0);
      for (int i = 0; i < 8; i++) bit_out(logic'((8'h81 >> i) & 1));
      bit_out(1'b1);
      repeat (40) @(negedge clk);
      expect_push({3'b010, 8'h3C});
      expect_push({3'b000, 8'h81});
      drain_all("R5 R7");

      // R6: second stop bit low is ignored
      cfg(2'd3, 1'b0, 1'b0, 1'b1);
      frame(8'h5A, 1'b0, 1'b1, 1'b0);
      expect_push({3'b000, 8'h5A});
      repeat (200) @(negedge clk);
      drain_all("R6");

      // R8: long break gives one entry, then normal traffic resumes
      cfg(2'd3, 1'b0, 1'b0, 1'b0);
      rxd = 1'b0;
      repeat (30 * 64) @(negedge clk);
      rxd = 1'b1;
      repeat (100) @(negedge clk);
      expect_push({3'b100, 8'h00});
      send_good(8'h77, 1'b0);
      drain_all("R8");

      // R9: clean head ahead of a faulty newest entry
      cfg(2'd3, 1'b1, 1'b0, 1'b0);
      send_good(8'h11, 1'b0);
      send_good(8'h22, 1'b1);
      check({st_break, st_frame, st_parity} === 3'b000, "R9", "flags follow head",
            32'({st_break, st_frame, st_parity}), 32'd0);
      drain_all("R9");

      // R11: overfill by two
      cfg(2'd3, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < DEPTH + 2; i++) send_good(8'(i * 7 + 3), 1'b0);
      check(expq.size() == DEPTH, "R11", "model depth", 32'(expq.size()), 32'(DEPTH));
      drain_all("R11");

      // R12: pops on an empty FIFO
      rd_data = 1'b1;
      repeat (3) @(negedge clk);
      rd_data = 1'b0;
      check(data_ready === 1'b0, "R12", "still empty", 32'(data_ready), 32'd0);
      send_good(8'hC3, 1'b0);
      drain_all("R12");

      // random traffic: R2 R3
      for (int k = 0; k < 20; k++) begin
         int n;
         cfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
         n = 1 + int'($urandom % 3);
         for (int j = 0; j < n; j++) send_good(8'($urandom), ($urandom % 4) == 0);
         drain_all("R2 R3 random");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule